// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small store of recently used virtual-to-physical page translations and searches all of them at once for every lookup. A requester presents a virtual address. One clock later the block returns a hit flag, the physical address, the access-permission bits of the page, and the page's cacheable and bufferable attributes. On a hit, the physical address is the stored frame base joined to the page offset, which passes through untranslated.

A miss is resolved outside the block. A table walker fetches the translation and writes it back through the refill port. If the page is already present, its slot is rewritten. Otherwise a round-robin pointer picks the victim slot. On a task switch, a flush input empties the store in one cycle so that no translation from the old address space can hit.

When translation is switched off, the block maps addresses flat. The physical address equals the virtual address, and a bypass flag tells downstream logic to skip the permission check.

Top module: `xlat_buffer`

## Requirements
- R1: After reset, every entry is invalid: `res_valid` is 0, and a translated lookup of any address reports `res_hit`=0.
- R2: A lookup presented with `lk_valid`=1 produces `res_valid`=1 exactly one clock later. In a cycle following one without `lk_valid`, `res_valid` is 0.
- R3: A translated lookup that hits reports `res_hit`=1, `res_bypass`=0 and a physical address of {stored frame number, vaddr[11:0]}. The 12-bit page offset passes through unchanged.
- R4: A translated lookup that misses reports `res_hit`=0 and zero in `res_paddr`, `res_ap`, `res_cach` and `res_buf`.
- R5: At most one valid entry matches any address. A refill for a page already held rewrites that entry, so a following lookup returns the new frame number and attributes.
- R6: Refills of new pages fill slots in round-robin order starting at slot 0 after reset or flush. Once the store holds its 64 entries, the next new page evicts the oldest one, and the other entries still hit.
- R7: `flush`=1 invalidates all entries at the next edge. A translated lookup in the same cycle reports a miss, a refill in the same cycle is discarded, and the replacement pointer returns to slot 0.
- R8: With `xlat_en`=0, a lookup reports `res_hit`=1, `res_bypass`=1, `res_paddr` equal to the virtual address, and zero permission and attribute bits.
- R9: Permission and attribute bits are kept per entry and returned with each hit, so two pages can report different values.
- R10: A lookup in the same cycle as a refill sees the contents as they were before that refill. The refilled page hits from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | 1 = translate, 0 = flat mapping |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number being refilled |
| fill_pfn | input | 20 | Physical frame number for the page |
| fill_ap | input | 2 | Access-permission bits for the page |
| fill_cach | input | 1 | Cacheable attribute for the page |
| fill_buf | input | 1 | Bufferable attribute for the page |
| res_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| res_hit | output | 1 | Translation found (or bypass) |
| res_bypass | output | 1 | Flat mapping used, no permission check |
| res_paddr | output | 32 | Physical address |
| res_ap | output | 2 | Access-permission bits |
| res_cach | output | 1 | Cacheable attribute |
| res_buf | output | 1 | Bufferable attribute |

## Verification
A flush can land in the same cycle as a lookup that would otherwise hit and a refill of a new page. The bench loads pages and then raises `flush`, `lk_valid` on a resident page and `fill_valid` on a fresh page at one clock edge. It expects a miss for that lookup, and misses for both the old page and the refilled page afterwards. The bench also exercises the overlap of a refill and a lookup of the same page, where the lookup must miss and the next lookup must hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int ADDR_W  = 32;
    parameter int OFS_W   = 12;
    parameter int ENTRIES = 64;
    parameter int AP_W    = 2;

    localparam int PN_W  = ADDR_W - OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
        logic [AP_W-1:0] ap;
        logic            cach;
        logic            buff;
    } tlb_entry_t;

    typedef struct packed {
        logic              hit;
        logic              bypass;
        logic [ADDR_W-1:0] paddr;
        logic [AP_W-1:0]   ap;
        logic              cach;
        logic              buff;
    } tlb_result_t;

    function automatic logic [ADDR_W-1:0] join_paddr(
        input logic [PN_W-1:0]   pfn,
        input logic [ADDR_W-1:0] vaddr
    );
        return {pfn, vaddr[OFS_W-1:0]};
    endfunction

    function automatic logic [PN_W-1:0] page_of(input logic [ADDR_W-1:0] vaddr);
        return vaddr[ADDR_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  tlb_entry_t      wr_data,
    input  logic [PN_W-1:0] lk_vpn,
    output logic            lk_hit,
    output tlb_entry_t      lk_data,
    input  logic [PN_W-1:0] fl_vpn,
    output logic            fl_hit,
    output logic [IW-1:0]   fl_idx
);
    logic [N-1:0] valid;
    tlb_entry_t   mem [N];
    logic [N-1:0] lk_match;
    logic [N-1:0] fl_match;

    // Valid bits: flush and reset clear all, a write sets the written slot.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Parallel compare for the lookup side and the refill side.
    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign lk_match[g] = valid[g] && (mem[g].vpn == lk_vpn);
            assign fl_match[g] = valid[g] && (mem[g].vpn == fl_vpn);
        end
    endgenerate

    always_comb begin
        lk_data = '0;
        fl_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) lk_data = lk_data | mem[i];
            if (fl_match[i]) fl_idx  = fl_idx | IW'(i);
        end
    end

    assign lk_hit = |lk_match;
    assign fl_hit = |fl_match;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match)) else $error("two entries match one page"); // R5

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid == '0)) else $error("entry valid after flush"); // R7

    AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid[$past(wr_idx)]) else $error("refill slot not valid"); // R6
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES,
    localparam int IW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          advance,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !flush && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1))
        else $error("pointer did not step"); // R6

    AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr == '0)) else $error("pointer not rewound"); // R7
endmodule

// File: rtl/tlb_result_reg.sv
module tlb_result_reg
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  tlb_result_t in_res,
    output logic        out_valid,
    output tlb_result_t out_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            out_res   <= in_valid ? in_res : '0;
        end
    end

    AST_RES_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("result missing"); // R2

    AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious result"); // R2
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_en,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic              fill_valid,
    input  logic [PN_W-1:0]   fill_vpn,
    input  logic [PN_W-1:0]   fill_pfn,
    input  logic [AP_W-1:0]   fill_ap,
    input  logic              fill_cach,
    input  logic              fill_buf,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_bypass,
    output logic [ADDR_W-1:0] res_paddr,
    output logic [AP_W-1:0]   res_ap,
    output logic              res_cach,
    output logic              res_buf
);
    logic             st_hit;
    tlb_entry_t       st_data;
    logic             fl_hit;
    logic [IDX_W-1:0] fl_idx;
    logic [IDX_W-1:0] rr;
    logic             wr_en;
    logic             alloc;
    logic [IDX_W-1:0] wr_idx;
    tlb_entry_t       wr_data;
    tlb_result_t      nxt;
    tlb_result_t      cur;

    // A flush discards a refill in the same cycle.
    assign wr_en  = fill_valid && !flush;
    assign alloc  = wr_en && !fl_hit;
    assign wr_idx = fl_hit ? fl_idx : rr;

    always_comb begin
        wr_data      = '0;
        wr_data.vpn  = fill_vpn;
        wr_data.pfn  = fill_pfn;
        wr_data.ap   = fill_ap;
        wr_data.cach = fill_cach;
        wr_data.buff = fill_buf;
    end

    tlb_entry_store #(.N(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .lk_vpn  (page_of(lk_vaddr)),
        .lk_hit  (st_hit),
        .lk_data (st_data),
        .fl_vpn  (fill_vpn),
        .fl_hit  (fl_hit),
        .fl_idx  (fl_idx)
    );

    tlb_rr_ptr #(.N(ENTRIES)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .advance (alloc),
        .ptr     (rr)
    );

    always_comb begin
        nxt = '0;
        if (!xlat_en) begin
            nxt.hit    = 1'b1;
            nxt.bypass = 1'b1;
            nxt.paddr  = lk_vaddr;
        end else if (st_hit && !flush) begin
            nxt.hit   = 1'b1;
            nxt.paddr = join_paddr(st_data.pfn, lk_vaddr);
            nxt.ap    = st_data.ap;
            nxt.cach  = st_data.cach;
            nxt.buff  = st_data.buff;
        end
    end

    tlb_result_reg u_res (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lk_valid),
        .in_res    (nxt),
        .out_valid (res_valid),
        .out_res   (cur)
    );

    assign res_hit    = cur.hit;
    assign res_bypass = cur.bypass;
    assign res_paddr  = cur.paddr;
    assign res_ap     = cur.ap;
    assign res_cach   = cur.cach;
    assign res_buf    = cur.buff;

    AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !xlat_en) |=> (res_hit && res_bypass && res_paddr == $past(lk_vaddr)))
        else $error("flat mapping broken"); // R8

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && xlat_en && flush) |=> !res_hit) else $error("hit during flush"); // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && xlat_en) |=> (!res_hit || res_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])))
        else $error("offset altered"); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_paddr == '0 && res_ap == '0 && !res_cach && !res_buf))
        else $error("miss carries data"); // R4
endmodule

// File: tb/tb_xlat_buffer.sv
module tb_xlat_buffer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        xlat_en, flush, lk_valid, fill_valid;
    logic [31:0] lk_vaddr;
    logic [19:0] fill_vpn, fill_pfn;
    logic [1:0]  fill_ap;
    logic        fill_cach, fill_buf;
    logic        res_valid, res_hit, res_bypass, res_cach, res_buf;
    logic [31:0] res_paddr;
    logic [1:0]  res_ap;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_buffer dut (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_ap(fill_ap), .fill_cach(fill_cach), .fill_buf(fill_buf),
        .res_valid(res_valid), .res_hit(res_hit), .res_bypass(res_bypass),
        .res_paddr(res_paddr), .res_ap(res_ap), .res_cach(res_cach), .res_buf(res_buf)
    );

    function automatic logic [19:0] pfn_of(input logic [19:0] vpn, input logic [19:0] salt);
        return vpn ^ 20'h5A5A5 ^ salt;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; fill_valid = 0; flush = 0;
    endtask

    // Issue one lookup and sample the registered result one clock later.
    task automatic lookup(input logic [31:0] va);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [19:0] salt);
        fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn_of(vpn, salt);
        fill_ap = vpn[1:0]; fill_cach = vpn[2]; fill_buf = vpn[3];
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [19:0] salt);
        @(negedge clk);
        set_fill(vpn, salt);
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] va, input logic [19:0] salt);
        lookup(va);
        chk(req, {res_valid, res_hit, res_bypass}, 3'b110);
        chk(req, res_paddr, {pfn_of(va[31:12], salt), va[11:0]});
        chk(req, {res_ap, res_cach, res_buf}, {va[13:12], va[14], va[15]});
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va);
        lookup(va);
        chk(req, {res_valid, res_hit, res_bypass}, 3'b100);
        chk(req, {res_paddr, res_ap, res_cach, res_buf}, 36'h0);
    endtask

    task automatic t_reset();
        chk("R1 res_valid after reset", res_valid, 0);
        expect_miss("R1 lookup after reset", 32'h0000_0ABC);
        @(negedge clk);
        chk("R2 idle result", res_valid, 0);
    endtask

    task automatic t_bypass();
        xlat_en = 0;
        lookup(32'hDEAD_BEEF);
        chk("R8 flat", {res_valid, res_hit, res_bypass}, 3'b111);
        chk("R8 paddr", res_paddr, 32'hDEAD_BEEF);
        chk("R8 attrs", {res_ap, res_cach, res_buf}, 4'h0);
        xlat_en = 1;
    endtask

    task automatic t_hit_attrs();
        refill(20'h0010F, 0);
        refill(20'h00100, 0);
        expect_hit("R3 hit page A", 32'h0010_F123, 0);
        expect_hit("R9 hit page B", 32'h0010_0FFF, 0);
        expect_miss("R4 unknown page", 32'h0777_7000);
    endtask

    task automatic t_overwrite();
        refill(20'h0010F, 20'h00F0F);
        expect_hit("R5 rewritten entry", 32'h0010_F456, 20'h00F0F);
    endtask

    task automatic t_same_rw();
        @(negedge clk);
        set_fill(20'h00300, 0);
        lk_valid = 1; lk_vaddr = 32'h0030_0010;
        @(negedge clk);
        idle();
        chk("R10 lookup sees old contents", {res_valid, res_hit}, 2'b10);
        expect_hit("R10 hit next cycle", 32'h0030_0010, 0);
    endtask

    task automatic t_flush_overlap();
        @(negedge clk);
        flush = 1; set_fill(20'h00400, 0);
        lk_valid = 1; lk_vaddr = 32'h0010_0000;
        @(negedge clk);
        idle();
        chk("R7 miss in flush cycle", {res_valid, res_hit}, 2'b10);
        expect_miss("R7 old page gone", 32'h0010_0000);
        expect_miss("R7 refill discarded", 32'h0040_0000);
        expect_miss("R7 other page gone", 32'h0030_0000);
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < 64; i++) refill(20'h00200 + 20'(i), 0);
        for (int i = 0; i < 64; i++) expect_hit("R6 full store", {20'h00200 + 20'(i), 12'h004}, 0);
        refill(20'h00500, 0);
        expect_miss("R6 oldest evicted", 32'h0020_0000);
        expect_hit("R6 second kept", 32'h0020_1000, 0);
        expect_hit("R6 newcomer", 32'h0050_0000, 0);
        refill(20'h00501, 0);
        expect_miss("R6 next victim", 32'h0020_1000);
    endtask

    initial begin
        rst = 1; xlat_en = 1; lk_vaddr = 0;
        fill_vpn = 0; fill_pfn = 0; fill_ap = 0; fill_cach = 0; fill_buf = 0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_bypass();
        t_hit_attrs();
        t_overwrite();
        t_same_rw();
        t_flush_overlap();
        t_round_robin();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule